// File: doc/BRIEF.md
# Serial Interrupt Slot Agent

This block is the peripheral end of a shared, open-drain serial interrupt line. It watches the sampled line level. A low run of four or more clocks is taken as a start frame, and its rising edge is the time reference for a train of data frames. Each data frame lasts three clocks: sample, recovery and turn-around. In the frame whose index matches its slot configuration, the agent reports the level of one local interrupt input. If that input is low, it pulls the line low in the sample clock, drives it high for the recovery clock, and then lets go. If the input is high, it leaves the line to the pull-up for the whole frame.

The agent also reads the stop frame to decide who may begin the next cycle. A two-clock low selects quiet mode. In quiet mode an idle agent whose interrupt input changes level pulls the line low for a single clock, which asks the host to send a start frame. A three-clock low selects continuous mode, in which only the host starts cycles. The pad logic outside the block turns the drive-enable and drive-value pair into an open-drain or push-pull pin.

Top module: `sirq_slot_agent`

## Requirements
- R1: Out of reset `drvEn` is 0 and `drvVal` is 1, and the agent is in continuous mode, so a change of `irqIn` makes no request.
- R2: Let E0 be the clock edge that samples `lineIn` high after four or more consecutive low samples. Counting from E0, the cycle after edge E0+3k is the sample clock of frame k, the next cycle is its recovery clock and the one after that is its turn-around clock. Frames run from 0 to FRAMES-1, and after the last one the agent is idle.
- R3: In the sample clock of frame `slotNum`, a captured interrupt level of 0 gives `drvEn`=1 and `drvVal`=0. A captured level of 1 gives `drvEn`=0.
- R4: In the recovery clock of frame `slotNum`, `drvEn`=1 with `drvVal`=1 if the agent drove low in the sample clock just before. Otherwise `drvEn`=0.
- R5: In every turn-around clock `drvEn` is 0.
- R6: `irqIn` is captured at the edge that enters the agent's own sample clock. Any later change has no effect on that frame's sample or recovery drive.
- R7: Apart from a start request (R10), `drvEn` is 0 in every cycle outside the agent's own sample and recovery clocks. A `slotNum` of FRAMES or more never gives a slot drive.
- R8: Whenever `drvEn` is 0, `drvVal` is 1.
- R9: A low run of exactly 2 clocks ended by a high sample selects quiet mode. A run of exactly 3 selects continuous mode. Runs of other lengths leave the mode unchanged.
- R10: In quiet mode, while no frames are running and `lineIn` is high, an edge at which `irqIn` differs from its value at the previous edge gives `drvEn`=1 and `drvVal`=0 for the next cycle only. This never happens in continuous mode or while frames are running.
- R11: A low run of four or more clocks ended by a high sample restarts the count at frame 0, even in the middle of a frame train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Synchronised level of the shared line (1 = high) |
| irqIn | input | 1 | Local interrupt level to report |
| slotNum | input | SLOT_W | Frame index assigned to this agent |
| drvEn | output | 1 | Line driver enable |
| drvVal | output | 1 | Level driven while enabled; 1 when released |

## Verification
All outputs come from registers, so each result appears exactly one edge after the stimulus that causes it. If the bench raises the line at the falling edge numbered c0, frame k's sample, recovery and turn-around results show up at the falling edges c0+1+3k, c0+2+3k and c0+3+3k. A start request shows up at the falling edge one after the `irqIn` change, and is gone at the next one. The driver task turns each stimulus into queue entries stamped with these absolute cycle numbers. The monitor compares `drvEn`/`drvVal` only at falling edges whose cycle count equals an entry's stamp, and it flags any entry whose cycle has passed without a comparison.

// File: rtl/sirq_slot_pkg.sv
package sirq_slot_pkg;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_RECOV  = 2'd1,
    PH_TURN   = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ownSample;  // agent's own sample clock
    logic ownRecov;   // agent's own recovery clock
    logic loadIrq;    // capture irqIn at this edge
    logic reqArm;     // idle in quiet mode: request allowed
  } ctlStrobe_t;

  // Line events from datapath to control
  typedef struct packed {
    logic startSeen;  // long low run just ended
    logic stopQuiet;  // two-clock low just ended
    logic stopCont;   // three-clock low just ended
  } lineEvt_t;

endpackage

// File: rtl/sirq_slot_dp.sv
module sirq_slot_dp
  import sirq_slot_pkg::*;
#(
  parameter int START_MIN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  input  logic       irqIn,
  input  ctlStrobe_t strobe,
  output lineEvt_t   evt,
  output logic       drvEn,
  output logic       drvVal
);

  localparam int RUN_W = $clog2(START_MIN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(START_MIN);

  logic [RUN_W-1:0] lowRun;
  logic irqQ;
  logic irqPrev;
  logic droveLow;
  logic reqPulse;
  logic lowSlot;
  logic highSlot;

  // Saturating count of consecutive low samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (lineIn) begin
      lowRun <= '0;
    end else if (lowRun != RUN_MAX) begin
      lowRun <= lowRun + 1'b1;
    end
  end

  always_comb begin
    evt.startSeen = lineIn && (lowRun == RUN_MAX);
    evt.stopQuiet = lineIn && (lowRun == RUN_W'(2));
    evt.stopCont  = lineIn && (lowRun == RUN_W'(3));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ     <= 1'b1;
      irqPrev  <= 1'b1;
      droveLow <= 1'b0;
      reqPulse <= 1'b0;
    end else begin
      if (strobe.loadIrq) irqQ <= irqIn;
      irqPrev  <= irqIn;
      droveLow <= strobe.ownSample & ~irqQ;
      reqPulse <= strobe.reqArm & lineIn & ~reqPulse & (irqIn != irqPrev);
    end
  end

  always_comb begin
    lowSlot  = strobe.ownSample & ~irqQ;
    highSlot = strobe.ownRecov & droveLow;
    drvEn    = lowSlot | highSlot | reqPulse;
    drvVal   = ~(lowSlot | reqPulse);
  end

endmodule

// File: rtl/sirq_slot_ctl.sv
module sirq_slot_ctl
  import sirq_slot_pkg::*;
#(
  parameter int FRAMES = 21,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] slotNum,
  input  lineEvt_t          evt,
  output ctlStrobe_t        strobe
);

  localparam int FR_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int CW   = ((FR_W > SLOT_W) ? FR_W : SLOT_W) + 1;
  localparam logic [FR_W-1:0] LAST = FR_W'(FRAMES - 1);

  logic            active;
  logic            quietMode;
  phase_e          phase;
  logic [FR_W-1:0] frame;
  logic [CW-1:0]   frameX;
  logic [CW-1:0]   nextX;
  logic [CW-1:0]   slotX;
  logic            ownFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      quietMode <= 1'b0;
      phase     <= PH_SAMPLE;
      frame     <= '0;
    end else begin
      if (evt.stopQuiet)     quietMode <= 1'b1;
      else if (evt.stopCont) quietMode <= 1'b0;

      if (evt.startSeen) begin
        active <= 1'b1;
        phase  <= PH_SAMPLE;
        frame  <= '0;
      end else if (active) begin
        case (phase)
          PH_SAMPLE: phase <= PH_RECOV;
          PH_RECOV:  phase <= PH_TURN;
          PH_TURN: begin
            phase <= PH_SAMPLE;
            if (frame == LAST) active <= 1'b0;
            else               frame  <= frame + 1'b1;
          end
          default:   phase <= PH_SAMPLE;
        endcase
      end
    end
  end

  always_comb begin
    frameX   = CW'(frame);
    nextX    = frameX + 1'b1;
    slotX    = CW'(slotNum);
    ownFrame = active && (frameX == slotX);

    strobe.ownSample = ownFrame && (phase == PH_SAMPLE);
    strobe.ownRecov  = ownFrame && (phase == PH_RECOV);
    if (evt.startSeen)
      strobe.loadIrq = (slotX == '0);
    else
      strobe.loadIrq = active && (phase == PH_TURN) && (frame != LAST) && (nextX == slotX);
    strobe.reqArm    = !active && quietMode && !evt.startSeen;
  end

endmodule

// File: rtl/sirq_slot_agent.sv
module sirq_slot_agent
  import sirq_slot_pkg::*;
#(
  parameter int FRAMES    = 21,
  parameter int SLOT_W    = 5,
  parameter int START_MIN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic              irqIn,
  input  logic [SLOT_W-1:0] slotNum,
  output logic              drvEn,
  output logic              drvVal
);

  ctlStrobe_t strobe;
  lineEvt_t   evt;

  sirq_slot_ctl #(
    .FRAMES (FRAMES),
    .SLOT_W (SLOT_W)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .slotNum (slotNum),
    .evt     (evt),
    .strobe  (strobe)
  );

  sirq_slot_dp #(
    .START_MIN (START_MIN)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .irqIn  (irqIn),
    .strobe (strobe),
    .evt    (evt),
    .drvEn  (drvEn),
    .drvVal (drvVal)
  );

endmodule

// File: rtl/sirq_slot_chk.sv
module sirq_slot_chk #(
  parameter int FRAMES = 21,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [SLOT_W-1:0] slotNum,
  input logic              drvEn,
  input logic              drvVal
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !drvEn);

  a_r8_released_high: assert property (@(posedge clk) disable iff (!rstN)
    !drvEn |-> drvVal);

  a_r4_high_only_after_low: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && drvVal) |-> $past(drvEn && !drvVal));

  a_r5_release_after_recovery: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && drvVal) |=> !(drvEn && drvVal));

  a_r7_no_slot_beyond_range: assert property (@(posedge clk) disable iff (!rstN)
    (int'(slotNum) >= FRAMES) |-> !(drvEn && drvVal));

endmodule

bind sirq_slot_agent sirq_slot_chk #(
  .FRAMES (FRAMES),
  .SLOT_W (SLOT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .slotNum (slotNum),
  .drvEn   (drvEn),
  .drvVal  (drvVal)
);

// File: tb/sim_sirq_slot_agent.sv
module sim_sirq_slot_agent;

  localparam int FRAMES = 21;
  localparam int SLOT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b1;
  logic irqIn = 1'b1;
  logic [SLOT_W-1:0] slotNum = 5'd3;
  logic drvEn;
  logic drvVal;

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    cyc;
    bit    en;
    bit    val;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  sirq_slot_agent #(
    .FRAMES    (FRAMES),
    .SLOT_W    (SLOT_W),
    .START_MIN (4)
  ) u0 (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (lineIn),
    .irqIn   (irqIn),
    .slotNum (slotNum),
    .drvEn   (drvEn),
    .drvVal  (drvVal)
  );

  // Monitor: compare at falling edges against stamped expectations
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      exp_t e;
      e = expQ.pop_front();
      nChecks++;
      if (e.cyc < cyc) begin
        nFail++;
        $display("FAIL %s: check for cycle %0d missed, actual cycle %0d expected %0d",
                 e.tag, e.cyc, cyc, e.cyc);
      end else if (drvEn !== e.en || drvVal !== e.val) begin
        nFail++;
        $display("FAIL %s: cycle %0d drvEn/drvVal actual %b/%b expected %b/%b",
                 e.tag, cyc, drvEn, drvVal, e.en, e.val);
      end
    end
  end

  task automatic push(input int c, input bit en, input bit val, input string tag);
    exp_t e;
    e.cyc = c;
    e.en  = en;
    e.val = val;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Called at a falling edge: hold the line low n clocks, then release
  task automatic lowPulse(input int n, output int cEnd);
    lineIn = 1'b0;
    repeat (n) @(negedge clk);
    lineIn = 1'b1;
    cEnd = cyc;
  endtask

  // Driver: expected drive for frames 0..nFr-1 after line rose at cycle c0
  task automatic expectFrames(input int c0, input int slot, input bit irqLvl,
                              input int nFr, input string tag);
    for (int f = 0; f < nFr; f++) begin
      for (int p = 0; p < 3; p++) begin
        int c;
        c = c0 + 1 + 3 * f + p;
        if (f == slot && p == 0)      push(c, !irqLvl, irqLvl, tag);
        else if (f == slot && p == 1) push(c, !irqLvl, 1'b1, tag);
        else                          push(c, 1'b0, 1'b1, tag);
      end
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic waitIdle();
    drain();
    repeat (70) @(negedge clk);
  endtask

  task automatic toggleIrq(output int c);
    irqIn = ~irqIn;
    c = cyc;
  endtask

  initial begin
    int c0;
    repeat (2) @(negedge clk);
    push(cyc + 1, 1'b0, 1'b1, "R1 reset outputs");
    push(cyc + 2, 1'b0, 1'b1, "R1 reset outputs");
    drain();
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: continuous after reset, no request
    toggleIrq(c0);
    push(c0 + 1, 1'b0, 1'b1, "R1 no request after reset");
    push(c0 + 2, 1'b0, 1'b1, "R1 no request after reset");
    drain();

    // R2 R3 R4 R5: slot 3, interrupt low
    slotNum = 5'd3; irqIn = 1'b0;
    lowPulse(4, c0);
    expectFrames(c0, 3, 1'b0, FRAMES, "R2 R3 R4 R5 slot3 low");
    waitIdle();

    // R3 R4: interrupt high, released throughout
    irqIn = 1'b1;
    lowPulse(4, c0);
    expectFrames(c0, 3, 1'b1, FRAMES, "R3 R4 slot3 high");
    waitIdle();

    // R6: change after capture edge does not alter frame 5
    irqIn = 1'b0; slotNum = 5'd5;
    lowPulse(4, c0);
    expectFrames(c0, 5, 1'b0, 8, "R6 capture before sample");
    repeat (16) @(posedge clk);
    #1 irqIn = 1'b1;
    waitIdle();

    // R7 boundaries
    irqIn = 1'b0; slotNum = 5'd0;
    lowPulse(4, c0);
    expectFrames(c0, 0, 1'b0, FRAMES, "R7 first slot");
    waitIdle();
    slotNum = 5'd20;
    lowPulse(4, c0);
    expectFrames(c0, 20, 1'b0, FRAMES, "R7 last slot");
    waitIdle();
    slotNum = 5'd25;
    lowPulse(4, c0);
    expectFrames(c0, 25, 1'b0, FRAMES, "R7 R8 slot out of range");
    waitIdle();

    // R11: restart in mid train
    slotNum = 5'd4;
    lowPulse(4, c0);
    expectFrames(c0, 4, 1'b0, 2, "R11 before restart");
    drain();
    lowPulse(5, c0);
    expectFrames(c0, 4, 1'b0, FRAMES, "R11 after restart");
    waitIdle();

    // R9: three-wide stop keeps host-only mode
    lowPulse(3, c0);
    repeat (3) @(negedge clk);
    toggleIrq(c0);
    push(c0 + 1, 1'b0, 1'b1, "R9 three-wide stop no request");
    push(c0 + 2, 1'b0, 1'b1, "R9 three-wide stop no request");
    drain();

    // R9 R10: two-wide stop enables quiet request
    lowPulse(2, c0);
    repeat (3) @(negedge clk);
    toggleIrq(c0);
    push(c0 + 1, 1'b1, 1'b0, "R10 quiet request pulse");
    push(c0 + 2, 1'b0, 1'b1, "R10 request one clock only");
    push(c0 + 3, 1'b0, 1'b1, "R10 request one clock only");
    drain();

    // R10: no request while frames run
    slotNum = 5'd25;
    lowPulse(4, c0);
    expectFrames(c0, 25, 1'b0, FRAMES, "R10 no request while framing");
    push(c0 + 3 * FRAMES + 1, 1'b0, 1'b1, "R10 no late request");
    push(c0 + 3 * FRAMES + 2, 1'b0, 1'b1, "R10 no late request");
    repeat (10) @(negedge clk);
    irqIn = ~irqIn;
    waitIdle();

    // R9: start frame leaves quiet mode in place
    toggleIrq(c0);
    push(c0 + 1, 1'b1, 1'b0, "R9 quiet kept across start frame");
    push(c0 + 2, 1'b0, 1'b1, "R9 quiet kept across start frame");
    drain();

    // R9: three-wide stop returns to host-only
    lowPulse(3, c0);
    repeat (3) @(negedge clk);
    toggleIrq(c0);
    push(c0 + 1, 1'b0, 1'b1, "R9 back to host-only");
    push(c0 + 2, 1'b0, 1'b1, "R9 back to host-only");
    drain();

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL R2 watchdog: actual %0d cycles without finishing, expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule